// File: doc/BRIEF.md
# Two-Stage Round-Robin Switch Allocator

This block decides, every clock, which buffered flits in a virtual-channel router may cross the switch. Every input virtual channel (VC) reports whether it is waiting for the switch, whether downstream credit exists, its routed output port, its assigned output VC, its flit type and an arrival stamp. The allocator runs two stages. First, each input port picks one of its own VCs. Second, each output port picks one of the input ports whose chosen VC is routed to it.

Every arbiter is round-robin. Its pointer steps once per clock whatever the outcome. Virtual networks marked as ordered add one rule: a VC may not overtake an older VC of the same input port and network that heads for the same output port.

Each grant comes out one cycle later, on four groups of outputs:
- a crossbar source select and output-VC tag for each output port;
- a one-hot credit decrement on the output VC;
- a credit return per input port, with a flag saying whether the VC is released;
- per-VC strobes that move the flit to switch traversal or return the VC to idle.

A separate wake output tells the router that some VC will want the switch on the next cycle.

Top module: `sa_switch_alloc`

## Requirements
- R1: While `rst` is high at a clock edge, every grant output is cleared and all arbiter pointers return to zero. The first edge after reset uses pointer 0 in both stages.
- R2: A VC is eligible in stage one only when all three of these hold: its request is high, its credit flag is high, and its route is below `N_OUT`. The ordering rule of R6 can also block it. A request without credit gives no grant.
- R3: Stage one scans the VCs of an input port from that port's pointer upward, wrapping at `NVC`, and keeps the first eligible VC. At most one VC per input port is granted per cycle.
- R4: Stage two scans input ports from the output's pointer upward, wrapping at `N_IN`. It grants the first input whose stage-one winner routes to that output. No input and no output gets more than one grant per cycle.
- R5: Every input pointer advances by one each cycle modulo `NVC`, and every output pointer advances by one modulo `N_IN`. This happens on every cycle, whether or not a grant was made.
- R6: The network of VC v is v / `VC_PER_VNET`. In a network whose bit in `ORDERED_VNETS` is set, VC v is blocked if another requesting VC of the same input and network has the same route and a strictly smaller stamp. Equal stamps do not block. Credit on the older VC does not matter.
- R7: For a granted output o, `xb_valid[o]` is 1, `xb_src[o]` is the input index and `xb_vc[o]` is the granted VC's output VC. `ocred_dec[o]` is one-hot at that output VC. All fields of an ungranted output read zero.
- R8: For a granted input i, `up_cred_valid[i]` is 1 and `up_cred_vc[i]` is the granted VC index. `vc_to_st` is set at that VC's flat index (i*NVC+v). Flit type is encoded 0 head, 1 body, 2 tail, 3 head-tail. For types 2 and 3, `up_cred_free[i]` and `vc_to_idle` at that index are also 1; for other types both are 0.
- R9: All grant outputs are registered and reflect the inputs sampled at the previous edge. A stage-one winner that loses stage two gets nothing, and no request is carried into a later cycle.
- R10: `wake` is the OR of all `vc_req_next` bits, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_req | input | N_IN*NVC | VC waits for switch allocation |
| vc_credit_ok | input | N_IN*NVC | Downstream credit available for the VC |
| vc_route | input | N_IN*NVC x OUT_W | Routed output port |
| vc_outvc | input | N_IN*NVC x VC_W | Output VC assigned to the VC |
| vc_ftype | input | N_IN*NVC x 2 | Flit type at the VC head |
| vc_stamp | input | N_IN*NVC x TS_W | Arrival stamp |
| vc_req_next | input | N_IN*NVC | VC will need allocation next cycle |
| wake | output | 1 | Allocation needed next cycle |
| xb_valid | output | N_OUT | Output port granted |
| xb_src | output | N_OUT x IN_W | Crossbar source input |
| xb_vc | output | N_OUT x VC_W | Output VC tag of the flit |
| ocred_dec | output | N_OUT x NVC | One-hot output-VC credit decrement |
| up_cred_valid | output | N_IN | Credit returned upstream |
| up_cred_vc | output | N_IN x VC_W | VC of the returned credit |
| up_cred_free | output | N_IN | Returned credit releases the VC |
| vc_to_st | output | N_IN*NVC | Flit moves to switch traversal |
| vc_to_idle | output | N_IN*NVC | VC goes idle, stamp cleared |

## Verification
In one cycle, ordering suppression and round-robin selection can act on the same input port. An older same-route VC must win even when the pointer sits on a younger one, while VCs of an unordered network still rotate. The bench provokes this by holding two same-route VCs in the ordered network across a full pointer revolution, once with distinct stamps and once with equal stamps, and by random traffic with narrow stamp and route ranges. The same random traffic makes stage-one winners collide at one output in a cycle, so the bench also checks that the loser receives no credit or traversal strobe. A behavioural model judges every cycle, field by field.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [1:0] {
        FT_HEAD = 2'd0,
        FT_BODY = 2'd1,
        FT_TAIL = 2'd2,
        FT_SOLO = 2'd3
    } ftype_e;

    // index width for a count, never zero
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // tail and single-flit packets release their VC
    function automatic logic frees_vc(input logic [1:0] ft);
        return (ft == FT_TAIL) || (ft == FT_SOLO);
    endfunction

endpackage

// File: rtl/sa_rr_pick.sv
module sa_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          found,
    output logic [PW-1:0] idx
);
    int k;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        k     = 0;
        for (int i = 0; i < N; i++) begin
            k = int'(ptr) + i;
            if (k >= N) k = k - N;
            if (!found && req[k]) begin
                found = 1'b1;
                idx   = PW'(k);
            end
        end
    end
endmodule

// File: rtl/sa_input_stage.sv
module sa_input_stage #(
    parameter int N_VNET      = 2,
    parameter int VC_PER_VNET = 2,
    parameter int N_OUT       = 3,
    parameter int TS_W        = 8,
    parameter logic [N_VNET-1:0] ORDERED_VNETS = 1,
    localparam int NVC   = N_VNET * VC_PER_VNET,
    localparam int VC_W  = sa_pkg::idx_w(NVC),
    localparam int OUT_W = sa_pkg::idx_w(N_OUT)
) (
    input  logic [NVC-1:0]            req,
    input  logic [NVC-1:0]            credit_ok,
    input  logic [NVC-1:0][OUT_W-1:0] route,
    input  logic [NVC-1:0][TS_W-1:0]  stamp,
    input  logic [VC_W-1:0]           ptr,
    output logic                      win_valid,
    output logic [VC_W-1:0]           win_vc
);
    logic [NVC-1:0] blocked_d;
    logic [NVC-1:0] elig_d;
    int base;

    always_comb begin
        blocked_d = '0;
        elig_d    = '0;
        base      = 0;
        for (int v = 0; v < NVC; v++) begin
            base = (v / VC_PER_VNET) * VC_PER_VNET;
            if (ORDERED_VNETS[v / VC_PER_VNET]) begin
                for (int j = 0; j < VC_PER_VNET; j++) begin
                    if ((base + j != v) && req[base + j] &&
                        (route[base + j] == route[v]) &&
                        (stamp[base + j] < stamp[v]))
                        blocked_d[v] = 1'b1;
                end
            end
            elig_d[v] = req[v] && credit_ok[v] && (int'(route[v]) < N_OUT) &&
                        !blocked_d[v];
        end
    end

    sa_rr_pick #(.N(NVC), .PW(VC_W)) u_pick (
        .req   (elig_d),
        .ptr   (ptr),
        .found (win_valid),
        .idx   (win_vc)
    );
endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
    parameter int N_IN        = 3,
    parameter int N_OUT       = 3,
    parameter int N_VNET      = 2,
    parameter int VC_PER_VNET = 2,
    parameter int TS_W        = 8,
    parameter logic [N_VNET-1:0] ORDERED_VNETS = 1,
    localparam int NVC   = N_VNET * VC_PER_VNET,
    localparam int NIV   = N_IN * NVC,
    localparam int VC_W  = sa_pkg::idx_w(NVC),
    localparam int IN_W  = sa_pkg::idx_w(N_IN),
    localparam int OUT_W = sa_pkg::idx_w(N_OUT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NIV-1:0]              vc_req,
    input  logic [NIV-1:0]              vc_credit_ok,
    input  logic [NIV-1:0][OUT_W-1:0]   vc_route,
    input  logic [NIV-1:0][VC_W-1:0]    vc_outvc,
    input  logic [NIV-1:0][1:0]         vc_ftype,
    input  logic [NIV-1:0][TS_W-1:0]    vc_stamp,
    input  logic [NIV-1:0]              vc_req_next,
    output logic                        wake,
    output logic [N_OUT-1:0]            xb_valid,
    output logic [N_OUT-1:0][IN_W-1:0]  xb_src,
    output logic [N_OUT-1:0][VC_W-1:0]  xb_vc,
    output logic [N_OUT-1:0][NVC-1:0]   ocred_dec,
    output logic [N_IN-1:0]             up_cred_valid,
    output logic [N_IN-1:0][VC_W-1:0]   up_cred_vc,
    output logic [N_IN-1:0]             up_cred_free,
    output logic [NIV-1:0]              vc_to_st,
    output logic [NIV-1:0]              vc_to_idle
);
    typedef struct packed {
        logic [N_IN-1:0][VC_W-1:0]  in_ptr;
        logic [N_OUT-1:0][IN_W-1:0] out_ptr;
        logic [N_OUT-1:0]           xb_valid;
        logic [N_OUT-1:0][IN_W-1:0] xb_src;
        logic [N_OUT-1:0][VC_W-1:0] xb_vc;
        logic [N_OUT-1:0][NVC-1:0]  ocred;
        logic [N_IN-1:0]            up_valid;
        logic [N_IN-1:0][VC_W-1:0]  up_vc;
        logic [N_IN-1:0]            up_free;
        logic [NIV-1:0]             to_st;
        logic [NIV-1:0]             to_idle;
    } state_t;

    state_t st_d, st_q;

    // stage one results
    logic [N_IN-1:0]             s1_valid;
    logic [N_IN-1:0][VC_W-1:0]   s1_vc;
    logic [N_IN-1:0][OUT_W-1:0]  s1_route;
    // stage two requests and results
    logic [N_OUT-1:0][N_IN-1:0]  s2_req;
    logic [N_OUT-1:0]            s2_found;
    logic [N_OUT-1:0][IN_W-1:0]  s2_idx;

    genvar gi, go;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_in
            sa_input_stage #(
                .N_VNET        (N_VNET),
                .VC_PER_VNET   (VC_PER_VNET),
                .N_OUT         (N_OUT),
                .TS_W          (TS_W),
                .ORDERED_VNETS (ORDERED_VNETS)
            ) u_stage (
                .req       (vc_req[gi*NVC +: NVC]),
                .credit_ok (vc_credit_ok[gi*NVC +: NVC]),
                .route     (vc_route[gi*NVC +: NVC]),
                .stamp     (vc_stamp[gi*NVC +: NVC]),
                .ptr       (st_q.in_ptr[gi]),
                .win_valid (s1_valid[gi]),
                .win_vc    (s1_vc[gi])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < N_IN; i++)
            s1_route[i] = vc_route[i*NVC + int'(s1_vc[i])];
        for (int o = 0; o < N_OUT; o++)
            for (int i = 0; i < N_IN; i++)
                s2_req[o][i] = s1_valid[i] && (int'(s1_route[i]) == o);
    end

    generate
        for (go = 0; go < N_OUT; go++) begin : g_out
            sa_rr_pick #(.N(N_IN), .PW(IN_W)) u_pick (
                .req   (s2_req[go]),
                .ptr   (st_q.out_ptr[go]),
                .found (s2_found[go]),
                .idx   (s2_idx[go])
            );
        end
    endgenerate

    int src, vsel, flat;

    always_comb begin
        st_d = '0;
        src  = 0;
        vsel = 0;
        flat = 0;
        for (int i = 0; i < N_IN; i++)
            st_d.in_ptr[i] = (st_q.in_ptr[i] == VC_W'(NVC - 1)) ? '0
                             : st_q.in_ptr[i] + VC_W'(1);
        for (int o = 0; o < N_OUT; o++)
            st_d.out_ptr[o] = (st_q.out_ptr[o] == IN_W'(N_IN - 1)) ? '0
                              : st_q.out_ptr[o] + IN_W'(1);
        for (int o = 0; o < N_OUT; o++) begin
            if (s2_found[o]) begin
                src  = int'(s2_idx[o]);
                vsel = int'(s1_vc[src]);
                flat = src * NVC + vsel;
                st_d.xb_valid[o]                   = 1'b1;
                st_d.xb_src[o]                     = s2_idx[o];
                st_d.xb_vc[o]                      = vc_outvc[flat];
                st_d.ocred[o][vc_outvc[flat]]      = 1'b1;
                st_d.up_valid[src]                 = 1'b1;
                st_d.up_vc[src]                    = s1_vc[src];
                st_d.up_free[src]                  = sa_pkg::frees_vc(vc_ftype[flat]);
                st_d.to_st[flat]                   = 1'b1;
                st_d.to_idle[flat]                 = sa_pkg::frees_vc(vc_ftype[flat]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wake          = |vc_req_next;
    assign xb_valid      = st_q.xb_valid;
    assign xb_src        = st_q.xb_src;
    assign xb_vc         = st_q.xb_vc;
    assign ocred_dec     = st_q.ocred;
    assign up_cred_valid = st_q.up_valid;
    assign up_cred_vc    = st_q.up_vc;
    assign up_cred_free  = st_q.up_free;
    assign vc_to_st      = st_q.to_st;
    assign vc_to_idle    = st_q.to_idle;
endmodule

// File: rtl/sa_switch_alloc_chk.sv
module sa_switch_alloc_chk #(
    parameter int N_IN        = 3,
    parameter int N_OUT       = 3,
    parameter int N_VNET      = 2,
    parameter int VC_PER_VNET = 2,
    parameter int TS_W        = 8,
    parameter logic [N_VNET-1:0] ORDERED_VNETS = 1,
    localparam int NVC   = N_VNET * VC_PER_VNET,
    localparam int NIV   = N_IN * NVC,
    localparam int VC_W  = sa_pkg::idx_w(NVC),
    localparam int IN_W  = sa_pkg::idx_w(N_IN),
    localparam int OUT_W = sa_pkg::idx_w(N_OUT)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NIV-1:0]              vc_req,
    input logic [NIV-1:0]              vc_credit_ok,
    input logic [NIV-1:0][OUT_W-1:0]   vc_route,
    input logic [NIV-1:0][VC_W-1:0]    vc_outvc,
    input logic [NIV-1:0][1:0]         vc_ftype,
    input logic [NIV-1:0][TS_W-1:0]    vc_stamp,
    input logic [NIV-1:0]              vc_req_next,
    input logic                        wake,
    input logic [N_OUT-1:0]            xb_valid,
    input logic [N_OUT-1:0][IN_W-1:0]  xb_src,
    input logic [N_OUT-1:0][VC_W-1:0]  xb_vc,
    input logic [N_OUT-1:0][NVC-1:0]   ocred_dec,
    input logic [N_IN-1:0]             up_cred_valid,
    input logic [N_IN-1:0][VC_W-1:0]   up_cred_vc,
    input logic [N_IN-1:0]             up_cred_free,
    input logic [NIV-1:0]              vc_to_st,
    input logic [NIV-1:0]              vc_to_idle
);
    logic [NIV-1:0] req_q, cred_q;

    always_ff @(posedge clk) begin
        req_q  <= vc_req;
        cred_q <= vc_credit_ok;
    end

    genvar gi, go;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_ci
            a_r3_one_vc_per_input: assert property (@(posedge clk) disable iff (rst)
                $onehot0(vc_to_st[gi*NVC +: NVC]));
            a_r8_free_needs_credit: assert property (@(posedge clk) disable iff (rst)
                up_cred_free[gi] |-> up_cred_valid[gi]);
            a_r2_grant_was_eligible: assert property (@(posedge clk) disable iff (rst)
                up_cred_valid[gi] |-> (req_q[gi*NVC + int'(up_cred_vc[gi])] &&
                                       cred_q[gi*NVC + int'(up_cred_vc[gi])]));
        end
        for (go = 0; go < N_OUT; go++) begin : g_co
            a_r7_dec_tracks_grant: assert property (@(posedge clk) disable iff (rst)
                $onehot0(ocred_dec[go]) && (xb_valid[go] == (ocred_dec[go] != '0)));
            a_r4_grant_reaches_input: assert property (@(posedge clk) disable iff (rst)
                xb_valid[go] |-> up_cred_valid[xb_src[go]]);
        end
    endgenerate

    a_r4_no_double_input: assert property (@(posedge clk) disable iff (rst)
        $countones(xb_valid) == $countones(up_cred_valid));
    a_r8_idle_only_on_move: assert property (@(posedge clk) disable iff (rst)
        (vc_to_idle & ~vc_to_st) == '0);
endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(
    .N_IN          (N_IN),
    .N_OUT         (N_OUT),
    .N_VNET        (N_VNET),
    .VC_PER_VNET   (VC_PER_VNET),
    .TS_W          (TS_W),
    .ORDERED_VNETS (ORDERED_VNETS)
) u_chk (.*);

// File: tb/sa_switch_alloc_test.sv
module sa_switch_alloc_test;
    localparam int N_IN = 3, N_OUT = 3, N_VNET = 2, VPV = 2, TS_W = 8;
    localparam int NVC = N_VNET * VPV, NIV = N_IN * NVC;
    localparam int VC_W = 2, IN_W = 2, OUT_W = 2;
    localparam logic [N_VNET-1:0] ORD = 2'b01;

    logic clk = 1'b0, rst = 1'b1;
    logic [NIV-1:0]            vc_req, vc_credit_ok, vc_req_next;
    logic [NIV-1:0][OUT_W-1:0] vc_route;
    logic [NIV-1:0][VC_W-1:0]  vc_outvc;
    logic [NIV-1:0][1:0]       vc_ftype;
    logic [NIV-1:0][TS_W-1:0]  vc_stamp;
    logic                      wake;
    logic [N_OUT-1:0]            xb_valid;
    logic [N_OUT-1:0][IN_W-1:0]  xb_src;
    logic [N_OUT-1:0][VC_W-1:0]  xb_vc;
    logic [N_OUT-1:0][NVC-1:0]   ocred_dec;
    logic [N_IN-1:0]             up_cred_valid;
    logic [N_IN-1:0][VC_W-1:0]   up_cred_vc;
    logic [N_IN-1:0]             up_cred_free;
    logic [NIV-1:0]              vc_to_st, vc_to_idle;

    // expected values
    logic [N_OUT-1:0]            e_xv;
    logic [N_OUT-1:0][IN_W-1:0]  e_xs;
    logic [N_OUT-1:0][VC_W-1:0]  e_xc;
    logic [N_OUT-1:0][NVC-1:0]   e_dec;
    logic [N_IN-1:0]             e_uv;
    logic [N_IN-1:0][VC_W-1:0]   e_uc;
    logic [N_IN-1:0]             e_uf;
    logic [NIV-1:0]              e_st, e_idle;

    int checks = 0, fails = 0;
    int in_p = 0, out_p = 0;

    sa_switch_alloc uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model();
        int  wv[N_IN];
        bit  wok[N_IN];
        e_xv = '0; e_xs = '0; e_xc = '0; e_dec = '0;
        e_uv = '0; e_uc = '0; e_uf = '0; e_st = '0; e_idle = '0;
        for (int i = 0; i < N_IN; i++) begin
            wok[i] = 0; wv[i] = 0;
            for (int k = 0; k < NVC; k++) begin
                int v = (in_p + k) % NVC;
                int f = i * NVC + v;
                bit ok = vc_req[f] && vc_credit_ok[f] && (int'(vc_route[f]) < N_OUT);
                if (ORD[v / VPV]) begin
                    for (int u = (v / VPV) * VPV; u < (v / VPV) * VPV + VPV; u++) begin
                        int g = i * NVC + u;
                        if (u != v && vc_req[g] && vc_route[g] == vc_route[f] &&
                            vc_stamp[g] < vc_stamp[f]) ok = 0;
                    end
                end
                if (ok && !wok[i]) begin wok[i] = 1; wv[i] = v; end
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            for (int k = 0; k < N_IN; k++) begin
                int i = (out_p + k) % N_IN;
                int f = i * NVC + wv[i];
                if (!e_xv[o] && wok[i] && int'(vc_route[f]) == o) begin
                    e_xv[o] = 1'b1;
                    e_xs[o] = IN_W'(i);
                    e_xc[o] = vc_outvc[f];
                    e_dec[o][vc_outvc[f]] = 1'b1;
                    e_uv[i] = 1'b1;
                    e_uc[i] = VC_W'(wv[i]);
                    e_uf[i] = vc_ftype[f] >= 2'd2;
                    e_st[f] = 1'b1;
                    e_idle[f] = vc_ftype[f] >= 2'd2;
                end
            end
        end
    endtask

    task automatic compare();
        chk(xb_valid == e_xv, "R4", "xb_valid", 64'(xb_valid), 64'(e_xv));
        chk(xb_src == e_xs, "R4", "xb_src", 64'(xb_src), 64'(e_xs));
        chk(xb_vc == e_xc, "R7", "xb_vc", 64'(xb_vc), 64'(e_xc));
        chk(ocred_dec == e_dec, "R7", "ocred_dec", 64'(ocred_dec), 64'(e_dec));
        chk(up_cred_valid == e_uv, "R8", "up_cred_valid", 64'(up_cred_valid), 64'(e_uv));
        chk(up_cred_vc == e_uc, "R8", "up_cred_vc", 64'(up_cred_vc), 64'(e_uc));
        chk(up_cred_free == e_uf, "R8", "up_cred_free", 64'(up_cred_free), 64'(e_uf));
        chk(vc_to_st == e_st, "R8", "vc_to_st", 64'(vc_to_st), 64'(e_st));
        chk(vc_to_idle == e_idle, "R8", "vc_to_idle", 64'(vc_to_idle), 64'(e_idle));
    endtask

    // inputs were set at a falling edge; sample, clock once, compare
    task automatic step();
        #1;
        chk(wake == (|vc_req_next), "R10", "wake", 64'(wake), 64'(|vc_req_next));
        model();
        @(posedge clk);
        in_p  = (in_p + 1) % NVC;
        out_p = (out_p + 1) % N_IN;
        @(negedge clk);
        compare();
    endtask

    task automatic clear_in();
        vc_req = '0; vc_credit_ok = '0; vc_route = '0; vc_outvc = '0;
        vc_ftype = '0; vc_stamp = '0; vc_req_next = '0;
    endtask

    task automatic set_vc(input int i, input int v, input int rt, input int ov,
                          input int ft, input int ts, input bit cr);
        int f = i * NVC + v;
        vc_req[f] = 1'b1; vc_credit_ok[f] = cr;
        vc_route[f] = OUT_W'(rt); vc_outvc[f] = VC_W'(ov);
        vc_ftype[f] = 2'(ft); vc_stamp[f] = TS_W'(ts);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        int seen2, seen3, seen_a, seen_b;
        clear_in();
        repeat (3) @(negedge clk);
        // R1: cleared outputs in reset
        chk(xb_valid == '0 && up_cred_valid == '0 && vc_to_st == '0 && ocred_dec == '0,
            "R1", "reset outputs", 64'(vc_to_st), 64'd0);
        rst = 1'b0; in_p = 0; out_p = 0;

        // R2: no credit, no grant
        clear_in(); set_vc(0, 2, 1, 3, 1, 0, 0);
        step();
        chk(up_cred_valid == '0, "R2", "grant without credit", 64'(up_cred_valid), 64'd0);

        // R6: older same-route VC wins in the ordered network at every pointer
        clear_in(); set_vc(0, 0, 0, 1, 0, 5, 1); set_vc(0, 1, 0, 2, 0, 2, 1);
        for (int n = 0; n < NVC; n++) begin
            step();
            chk(up_cred_valid[0] && up_cred_vc[0] == 2'd1, "R6", "oldest wins",
                64'(up_cred_vc[0]), 64'd1);
        end
        // R6: equal stamps do not block, pointer picks both
        clear_in(); set_vc(0, 0, 0, 1, 0, 4, 1); set_vc(0, 1, 0, 2, 0, 4, 1);
        seen_a = 0; seen_b = 0;
        for (int n = 0; n < NVC; n++) begin
            step();
            if (up_cred_vc[0] == 2'd0) seen_a++;
            if (up_cred_vc[0] == 2'd1) seen_b++;
        end
        chk(seen_a > 0 && seen_b > 0, "R6", "tie rotation", 64'(seen_a), 64'(seen_b));

        // R3: unordered network rotates regardless of age
        clear_in(); set_vc(0, 2, 1, 0, 1, 1, 1); set_vc(0, 3, 1, 3, 1, 9, 1);
        seen2 = 0; seen3 = 0;
        for (int n = 0; n < NVC; n++) begin
            step();
            if (up_cred_vc[0] == 2'd2) seen2++;
            if (up_cred_vc[0] == 2'd3) seen3++;
        end
        chk(seen2 > 0 && seen3 > 0, "R3", "vc rotation", 64'(seen2), 64'(seen3));

        // R5: two inputs on one output share it over a pointer revolution
        clear_in(); set_vc(1, 0, 2, 0, 0, 0, 1); set_vc(2, 0, 2, 1, 0, 0, 1);
        seen_a = 0; seen_b = 0;
        for (int n = 0; n < N_IN; n++) begin
            step();
            chk(xb_valid[2] == 1'b1, "R5", "output busy", 64'(xb_valid), 64'd4);
            if (xb_src[2] == 2'd1) seen_a++;
            if (xb_src[2] == 2'd2) seen_b++;
        end
        chk(seen_a > 0 && seen_b > 0, "R5", "input rotation", 64'(seen_a), 64'(seen_b));

        // R9: one-cycle collision, loser not remembered
        clear_in(); set_vc(0, 2, 0, 0, 1, 0, 1); set_vc(1, 2, 0, 1, 1, 0, 1);
        step();
        chk($countones(up_cred_valid) == 1, "R9", "single winner",
            64'($countones(up_cred_valid)), 64'd1);
        clear_in();
        step();
        chk(up_cred_valid == '0 && xb_valid == '0, "R9", "no carry over",
            64'(up_cred_valid), 64'd0);

        // R8: free marking by flit type
        clear_in(); set_vc(2, 3, 1, 2, 3, 0, 1);
        step();
        chk(up_cred_free[2] && vc_to_idle[2*NVC+3], "R8", "head-tail frees",
            64'(vc_to_idle), 64'(1 << (2*NVC+3)));
        clear_in(); set_vc(2, 3, 1, 2, 1, 0, 1);
        step();
        chk(!up_cred_free[2] && vc_to_idle == '0, "R8", "body keeps vc",
            64'(vc_to_idle), 64'd0);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            for (int f = 0; f < NIV; f++) begin
                vc_req[f]       = ($urandom % 3) != 0;
                vc_credit_ok[f] = ($urandom % 4) != 0;
                vc_route[f]     = OUT_W'($urandom % 4);
                vc_outvc[f]     = VC_W'($urandom % NVC);
                vc_ftype[f]     = 2'($urandom % 4);
                vc_stamp[f]     = TS_W'($urandom % 4);
                vc_req_next[f]  = ($urandom % 8) == 0;
            end
            step();
        end

        // R1: mid-run reset restarts pointers
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(xb_valid == '0 && up_cred_valid == '0 && vc_to_st == '0, "R1",
            "mid-run reset", 64'(vc_to_st), 64'd0);
        rst = 1'b0; in_p = 0; out_p = 0;
        for (int n = 0; n < 40; n++) begin
            for (int f = 0; f < NIV; f++) begin
                vc_req[f]       = ($urandom % 2) != 0;
                vc_credit_ok[f] = 1'b1;
                vc_route[f]     = OUT_W'($urandom % 3);
                vc_outvc[f]     = VC_W'($urandom % NVC);
                vc_ftype[f]     = 2'($urandom % 4);
                vc_stamp[f]     = TS_W'($urandom % 3);
                vc_req_next[f]  = 1'b0;
            end
            step();
        end
        finish_run();
    end
endmodule